// File: doc/BRIEF.md
# Stopwatch Timer with Control Register

This block is a software-driven stopwatch. A timebase enable pulse arrives at 32.768 kHz. A prescaler divides it down to a 256 Hz stage. A fractional accumulator then turns that stage into a 100 Hz tick that advances two BCD digits: hundredths of a second in the low field and tenths of a second in the high field. Software reaches the block through a small register bus, using a write strobe, a read strobe, an address and a 4-bit data word.

One control register holds two bits:
- a run bit, which reads back its value;
- a clear strobe, which acts only on write and always reads as zero.

The clear strobe zeroes the digits and the prescaler but leaves the run state alone. The stopwatch therefore either keeps counting from zero or stays held at zero. Stopping freezes the count, and a later run resumes from the frozen value.

Each digit raises its own interrupt flag when it wraps from 9 to 0. Software clears a flag by writing 1 to its bit. The interrupt request output is the OR of the flags that are enabled by a mask register. While running, the two digits are read by separate accesses, so a carry that lands between the two reads can tear the pair. Software should stop the stopwatch before it reads the count.

Top module: `stopwatch_ctl`

## Requirements
- R1: Register map:
  - 0x7B: mask, bits 1:0, read/write.
  - 0x7C: hundredths digit, read only.
  - 0x7D: tenths digit, read only.
  - 0x7E: control, with the clear strobe on bit 1 and run on bit 2.
  - 0x7F: flags, with the low flag on bit 0 and the high flag on bit 1.

  Read data appears on `rdata` after the clock edge that samples `rd_en`. Unmapped addresses read 0.
- R2: While running, every PRE_DIV timebase pulses make one 256 Hz stage. After m stages since the last clear, the count in hundredths equals floor(100*m/256). The low digit holds that count mod 10 and the high digit holds (count/10) mod 10, both in BCD.
- R3: Writing 1 to control bit 1 zeroes both digits and the prescaler. Writing 0 to that bit changes nothing. Control bit 1 always reads 0.
- R4: A clear written while running leaves run at 1, and counting restarts from zero with no stop.
- R5: A clear written while stopped leaves the count at zero until run is set.
- R6: Writing control bit 2 as 1 starts counting and as 0 stops it. The bit reads back its value. While stopped the count is held, and a later run resumes from the held count.
- R7: The low flag sets when the hundredths digit wraps from 9 to 0. The high flag sets when the tenths digit wraps from 9 to 0. Writing 1 to a flag bit clears only that flag, and writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R8: After the synchronous reset `rst`, the following are all 0: run, flags, mask, both digits and `irq`.
- R9: `irq` goes high one cycle after any flag is 1 while its mask bit is 1, and it is low when no enabled flag is set.
- R10: A single control write that sets both the clear bit and the run bit zeroes the count first and then runs from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The effects of faults show up at the ports in different ways and at different times:
- A wrong prescaler or accumulator phase appears only as a count that is off after many stages. For this reason the bench drives exact numbers of timebase pulses and compares the stopped count with the floor(100*m/256) rule.
- A stuck run bit or a clear that is ignored shows up on the next read of the digits or of the control register.
- A flag that is wrongly set or wrongly cleared shows on the flag read at once.
- A flag error reaches `irq` one cycle later, but only when the mask enables that flag.
- A missed tenths carry stays hidden until the count passes ten hundredths. The bench therefore runs one full second so that both wrap events occur.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef logic [3:0] bcd_t;
  localparam int NDIG        = 2;
  localparam bcd_t BCD_TOP   = 4'd9;
  localparam int CTL_CLR_BIT = 1;
  localparam int CTL_RUN_BIT = 2;
endpackage

// File: rtl/sw_prescale.sv
module sw_prescale #(
  parameter int PRE_DIV  = 128,
  parameter int RATE_NUM = 100,
  parameter int RATE_DEN = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tb_tick,
  output logic tick_o
);
  localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int AW = $clog2(RATE_NUM + RATE_DEN) + 1;

  logic [CW-1:0] div_q;
  logic [AW-1:0] acc_q, acc_sum;
  logic          div_last, stage;

  assign div_last = (div_q == CW'(PRE_DIV - 1));
  assign stage    = run && tb_tick && div_last;
  assign acc_sum  = acc_q + AW'(RATE_NUM);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q  <= '0;
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (run && tb_tick)
        div_q <= div_last ? '0 : div_q + 1'b1;
      if (stage) begin
        if (acc_sum >= AW'(RATE_DEN)) begin
          acc_q  <= acc_sum - AW'(RATE_DEN);
          tick_o <= 1'b1;
        end else begin
          acc_q <= acc_sum;
        end
      end
    end
  end

  // R2: a 100 Hz tick only follows a running stage
  p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(run));
  // R2: phase accumulator stays below one full period
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    acc_q < AW'(RATE_DEN));
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
  import sw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc_i,
  output bcd_t dig_o,
  output logic wrap_o
);
  assign wrap_o = inc_i && (dig_o == BCD_TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)
      dig_o <= '0;
    else if (inc_i)
      dig_o <= wrap_o ? '0 : dig_o + 1'b1;
  end

  // R2: digit never leaves the BCD range
  p_bcd_range_r2: assert property (@(posedge clk) disable iff (rst)
    dig_o <= BCD_TOP);
endmodule

// File: rtl/stopwatch_ctl.sv
module stopwatch_ctl
  import sw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 4,
  parameter int PRE_DIV  = 128,
  parameter int RATE_NUM = 100,
  parameter int RATE_DEN = 256,
  parameter int ADR_MSK  = 'h7B,
  parameter int ADR_LO   = 'h7C,
  parameter int ADR_HI   = 'h7D,
  parameter int ADR_CTL  = 'h7E,
  parameter int ADR_FLG  = 'h7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic wr_ctl, wr_flg, wr_msk, clr, run_q, tick_w;
  logic [NDIG-1:0] inc, wrap, flag_q, mask_q;
  bcd_t [NDIG-1:0] dig_w;
  logic [DATA_W-1:0] rd_val;
  logic unused_bits;

  assign unused_bits = ^wdata[DATA_W-1:3];
  assign wr_ctl = wr_en && (addr == ADDR_W'(ADR_CTL));
  assign wr_flg = wr_en && (addr == ADDR_W'(ADR_FLG));
  assign wr_msk = wr_en && (addr == ADDR_W'(ADR_MSK));
  assign clr    = wr_ctl && wdata[CTL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst)         run_q <= 1'b0;
    else if (wr_ctl) run_q <= wdata[CTL_RUN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (wr_msk) mask_q <= wdata[NDIG-1:0];
  end

  sw_prescale #(
    .PRE_DIV(PRE_DIV), .RATE_NUM(RATE_NUM), .RATE_DEN(RATE_DEN)
  ) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .run(run_q),
    .tb_tick(tb_tick), .tick_o(tick_w)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == 0) begin : g_first
      assign inc[i] = tick_w && run_q;
    end else begin : g_chain
      assign inc[i] = wrap[i-1];
    end

    sw_bcd_digit u_dig (
      .clk(clk), .rst(rst), .clr(clr), .inc_i(inc[i]),
      .dig_o(dig_w[i]), .wrap_o(wrap[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                     flag_q[i] <= 1'b0;
      else if (wrap[i])            flag_q[i] <= 1'b1;
      else if (wr_flg && wdata[i]) flag_q[i] <= 1'b0;
    end

    // R7: a wrap always leaves its flag set
    p_flag_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      wrap[i] |=> flag_q[i]);
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(ADR_LO))       rd_val = DATA_W'(dig_w[0]);
    else if (addr == ADDR_W'(ADR_HI))  rd_val = DATA_W'(dig_w[1]);
    else if (addr == ADDR_W'(ADR_CTL)) rd_val[CTL_RUN_BIT] = run_q;
    else if (addr == ADDR_W'(ADR_FLG)) rd_val[NDIG-1:0] = flag_q;
    else if (addr == ADDR_W'(ADR_MSK)) rd_val[NDIG-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq <= |(flag_q & mask_q);
    end
  end

  // R6: stopped and not cleared means the count is frozen
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !clr) |=> $stable(dig_w));
  // R3: a clear strobe zeroes both digits
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dig_w == '0));
  // R3: the clear bit never reads back as 1
  p_clr_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(ADR_CTL)) |=> !rdata[CTL_CLR_BIT]);
  // R9: with everything masked no request is raised
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);
endmodule

// File: tb/tb_stopwatch_ctl.sv
module tb_stopwatch_ctl;
  localparam int PDIV = 2;
  logic clk = 1'b0, rst = 1'b1, tb_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  int run_pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stopwatch_ctl #(.PRE_DIV(PDIV)) dut (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tb_tick = 1'b1;
    end
    @(negedge clk); tb_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int hundredths(input int p);
    return ((p / PDIV) * 100) / 256;
  endfunction

  task automatic expect_count(input int p, input string req);
    int lo, hi, t;
    t = hundredths(p);
    rd(8'h7C, lo);
    rd(8'h7D, hi);
    check(lo == t % 10, req, lo, t % 10);
    check(hi == (t / 10) % 10, req, hi, (t / 10) % 10);
  endtask

  task automatic t_reset_state;
    int v;
    rd(8'h7E, v); check(v == 0, "R8 ctl", v, 0);
    rd(8'h7F, v); check(v == 0, "R8 flags", v, 0);
    rd(8'h7B, v); check(v == 0, "R8 mask", v, 0);
    expect_count(0, "R8 count");
    check(irq == 1'b0, "R8 irq", int'(irq), 0);
    rd(8'h10, v); check(v == 0, "R1 unmapped", v, 0);
  endtask

  task automatic t_run_count;
    int v;
    wr(8'h7E, 4'h6);
    run_pulses = 0;
    rd(8'h7E, v); check(v == 4, "R10 ctl after clear+run", v, 4);
    pulses(60); run_pulses += 60;
    expect_count(run_pulses, "R2 count 11");
    rd(8'h7F, v); check(v == 1, "R7 low flag", v, 1);
  endtask

  task automatic t_stop_resume;
    wr(8'h7E, 4'h0);
    pulses(40);
    expect_count(run_pulses, "R6 hold");
    wr(8'h7E, 4'h4);
    pulses(100); run_pulses += 100;
    expect_count(run_pulses, "R6 resume R3 zero-write");
  endtask

  task automatic t_clear_running;
    int v;
    wr(8'h7E, 4'h6);
    run_pulses = 0;
    pulses(20); run_pulses += 20;
    expect_count(run_pulses, "R4 restart");
    rd(8'h7E, v); check(v == 4, "R4 run kept", v, 4);
  endtask

  task automatic t_clear_stopped;
    int v;
    wr(8'h7E, 4'h0);
    wr(8'h7E, 4'h2);
    expect_count(0, "R5 cleared");
    pulses(30);
    expect_count(0, "R5 held");
    rd(8'h7E, v); check(v == 0, "R5 run off", v, 0);
  endtask

  task automatic t_flags_irq;
    int v;
    check(irq == 1'b0, "R9 masked", int'(irq), 0);
    wr(8'h7B, 4'h1);
    @(negedge clk);
    check(irq == 1'b1, "R9 enabled", int'(irq), 1);
    wr(8'h7F, 4'h2);
    rd(8'h7F, v); check(v == 1, "R7 other bit kept", v, 1);
    check(irq == 1'b1, "R9 still", int'(irq), 1);
    wr(8'h7F, 4'h1);
    rd(8'h7F, v); check(v == 0, "R7 cleared", v, 0);
    @(negedge clk);
    check(irq == 1'b0, "R9 dropped", int'(irq), 0);
  endtask

  task automatic t_full_second;
    int v;
    wr(8'h7E, 4'h6);
    run_pulses = 0;
    pulses(256 * PDIV); run_pulses += 256 * PDIV;
    wr(8'h7E, 4'h0);
    expect_count(run_pulses, "R2 wrap 100");
    rd(8'h7F, v); check(v == 3, "R7 both flags", v, 3);
    wr(8'h7B, 4'h2);
    @(negedge clk);
    check(irq == 1'b1, "R9 high flag", int'(irq), 1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_run_count();
    t_stop_resume();
    t_clear_running();
    t_clear_stopped();
    t_flags_irq();
    t_full_second();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule